// File: doc/BRIEF.md
# Parallel Enumeration Rank Sorter

This block sorts a batch of N keys into ascending order by ranking rather than by exchanging. Keys arrive one per cycle on a serial load port. Once the batch is complete, the block copies the key vector into a second register bank. It then evaluates an N×N grid of comparison cells. Cell (g, p) compares the row key g, held in bank B, against the column key p, held in bank C, and raises a one-bit flag when the row key should sort at or after the column key.

Each row adds up its flags. The total is the 1-based rank of that row's key. Every key is then written into the output slot given by its rank minus one. Finally the sorted vector is streamed out one key per cycle with a valid strobe, followed by a single-cycle done pulse.

Equal keys are separated by their load index, so the ranks always form a permutation of 1..N. The controller is an FSM with these states:

- S_LOAD
- S_COPY
- S_COMPARE
- S_SUM
- S_SCATTER
- S_EMIT
- S_DONE

It has these transitions:

- LOAD→COPY when the N-th key is accepted.
- COPY→COMPARE, COMPARE→SUM, SUM→SCATTER and SCATTER→EMIT, each unconditional after one cycle.
- EMIT→DONE after the N-th output key.
- DONE→LOAD, unconditional.

Top module: `rank_sort_top`

## Requirements
- R1: After reset, out_valid and done are 0 and the block is in S_LOAD, ready to accept keys.
- R2: In S_LOAD, each cycle with in_valid=1 stores in_key at the next load index, counting from 0. The N-th accepted key ends loading.
- R3: in_valid and in_key have no effect outside S_LOAD. The sorted output of the current batch is unchanged by them.
- R4: The cell for row g and column p flags 1 when key[p] < key[g], or when key[p] == key[g] and p <= g. Otherwise it flags 0.
- R5: The rank of key g is the count of flags in row g. The N ranks are each in 1..N and form a permutation.
- R6: The key with rank R is emitted in output position R−1. The output sequence is therefore non-decreasing, and it is the stable ascending sort of the input.
- R7: out_valid rises on the fourth clock edge after the edge that accepts the last key. It then stays high for exactly N consecutive cycles.
- R8: done is high for exactly one cycle, the cycle directly after the last valid key. The block then returns to S_LOAD.
- R9: With N=6, the input 9, 2, 6, 4, 7, 8 yields the outputs 2, 4, 6, 7, 8, 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Key present on in_key |
| in_key | input | W | Key to load |
| out_valid | output | 1 | out_key carries a sorted key |
| out_key | output | W | Sorted key, ascending order |
| done | output | 1 | One-cycle pulse after the last sorted key |

## Verification
The hardest situation to reach is a batch in which many keys are equal, because only the index tie-break keeps the row sums distinct. Without it, two rows would claim the same output slot and another slot would be left empty. The stimulus therefore includes an all-equal batch and random batches drawn from a very small key range, so that duplicates are dense. During every processing phase the driver also keeps in_valid high with junk keys, which shows that inputs outside loading leave the sorted stream unchanged.

// File: rtl/rank_sort_pkg.sv
package rank_sort_pkg;
    typedef enum logic [2:0] {
        S_LOAD    = 3'd0,
        S_COPY    = 3'd1,
        S_COMPARE = 3'd2,
        S_SUM     = 3'd3,
        S_SCATTER = 3'd4,
        S_EMIT    = 3'd5,
        S_DONE    = 3'd6
    } sort_state_e;
endpackage

// File: rtl/rank_cell_array.sv
// N x N comparison grid: row key (bank B) against column key (bank C).
module rank_cell_array #(
    parameter int N = 6,
    parameter int W = 8
) (
    input  logic [N-1:0][W-1:0] row_keys,
    input  logic [N-1:0][W-1:0] col_keys,
    output logic [N-1:0][N-1:0] flags
);
    for (genvar g = 0; g < N; g++) begin : g_row
        for (genvar p = 0; p < N; p++) begin : g_col
            if (p <= g) begin : g_tie_low
                // R4: equal keys with lower-or-same column index count
                assign flags[g][p] = (col_keys[p] <= row_keys[g]);
            end else begin : g_tie_high
                assign flags[g][p] = (col_keys[p] < row_keys[g]);
            end
        end
    end
endmodule

// File: rtl/rank_row_sum.sv
// Per-row population count of the comparison flags gives each key's rank.
module rank_row_sum #(
    parameter int N  = 6,
    parameter int RW = 3
) (
    input  logic [N-1:0][N-1:0]  flags,
    output logic [N-1:0][RW-1:0] ranks
);
    for (genvar g = 0; g < N; g++) begin : g_row
        always_comb begin
            ranks[g] = '0;
            for (int p = 0; p < N; p++) begin
                ranks[g] = ranks[g] + RW'(flags[g][p]);
            end
        end
    end
endmodule

// File: rtl/rank_scatter.sv
// Places each key in slot rank-1.
module rank_scatter #(
    parameter int N  = 6,
    parameter int W  = 8,
    parameter int RW = 3
) (
    input  logic [N-1:0][W-1:0]  keys,
    input  logic [N-1:0][RW-1:0] ranks,
    output logic [N-1:0][W-1:0]  slots
);
    for (genvar s = 0; s < N; s++) begin : g_slot
        always_comb begin
            slots[s] = '0;
            for (int g = 0; g < N; g++) begin
                if (ranks[g] == RW'(s + 1)) begin
                    slots[s] = slots[s] | keys[g];
                end
            end
        end
    end
endmodule

// File: rtl/rank_sort_top.sv
module rank_sort_top
    import rank_sort_pkg::*;
#(
    parameter int N = 6,
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_key,
    output logic         out_valid,
    output logic [W-1:0] out_key,
    output logic         done
);
    localparam int RW = $clog2(N + 1);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    sort_state_e state_q, state_d;

    logic [IW-1:0]         idx_q;
    logic [N-1:0][W-1:0]   bank_b_q;
    logic [N-1:0][W-1:0]   bank_c_q;
    logic [N-1:0][N-1:0]   flags_d, flags_q;
    logic [N-1:0][RW-1:0]  rank_d, rank_q;
    logic [N-1:0][W-1:0]   sorted_d, sorted_q;

    rank_cell_array #(.N(N), .W(W)) u_cells (
        .row_keys (bank_b_q),
        .col_keys (bank_c_q),
        .flags    (flags_d)
    );

    rank_row_sum #(.N(N), .RW(RW)) u_sum (
        .flags (flags_q),
        .ranks (rank_d)
    );

    rank_scatter #(.N(N), .W(W), .RW(RW)) u_scatter (
        .keys  (bank_b_q),
        .ranks (rank_q),
        .slots (sorted_d)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_LOAD:    if (in_valid && idx_q == LAST_IDX) state_d = S_COPY;
            S_COPY:    state_d = S_COMPARE;
            S_COMPARE: state_d = S_SUM;
            S_SUM:     state_d = S_SCATTER;
            S_SCATTER: state_d = S_EMIT;
            S_EMIT:    if (idx_q == LAST_IDX) state_d = S_DONE;
            S_DONE:    state_d = S_LOAD;
            default:   state_d = S_LOAD;
        endcase
    end

    // Datapath registers, each phase gated by its state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            bank_b_q <= '0;
            bank_c_q <= '0;
            flags_q  <= '0;
            rank_q   <= '0;
            sorted_q <= '0;
        end else begin
            unique case (state_q)
                S_LOAD: begin
                    if (in_valid) begin
                        bank_b_q[idx_q] <= in_key;
                        idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
                    end
                end
                S_COPY:    bank_c_q <= bank_b_q;
                S_COMPARE: flags_q  <= flags_d;
                S_SUM:     rank_q   <= rank_d;
                S_SCATTER: begin
                    sorted_q <= sorted_d;
                    idx_q    <= '0;
                end
                S_EMIT:    idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
                S_DONE:    idx_q <= '0;
                default:   idx_q <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        out_valid = 1'b0;
        out_key   = '0;
        done      = 1'b0;
        unique case (state_q)
            S_EMIT: begin
                out_valid = 1'b1;
                out_key   = sorted_q[idx_q];
            end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/rank_sort_checker.sv
module rank_sort_checker
    import rank_sort_pkg::*;
#(
    parameter int N  = 6,
    parameter int W  = 8,
    parameter int RW = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 out_valid,
    input logic [W-1:0]         out_key,
    input logic                 done,
    input sort_state_e          st,
    input logic [N-1:0][RW-1:0] ranks
);
    logic [N-1:0] seen;
    always_comb begin
        seen = '0;
        for (int g = 0; g < N; g++) begin
            if (int'(ranks[g]) >= 1 && int'(ranks[g]) <= N) begin
                seen[int'(ranks[g]) - 1] = 1'b1;
            end
        end
    end

    AST_RANK_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SCATTER) |-> (&seen)) else $error("rank permutation"); // R5

    AST_ASCENDING_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_key >= $past(out_key))) else $error("order"); // R6

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid)) else $error("done placement"); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done width"); // R8

    AST_DONE_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && out_valid)) else $error("done with valid"); // R8

    AST_VALID_ONLY_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (st == S_EMIT)) else $error("valid outside emit"); // R7
endmodule

bind rank_sort_top rank_sort_checker #(.N(N), .W(W), .RW(RW)) u_rank_sort_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_key   (out_key),
    .done      (done),
    .st        (state_q),
    .ranks     (rank_q)
);

// File: tb/test_rank_sort_top.sv
`timescale 1ns/1ps
module test_rank_sort_top;
    localparam int N = 6;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_key = '0;
    logic         out_valid;
    logic [W-1:0] out_key;
    logic         done;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] exp_q[$];
    logic prev_valid = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    rank_sort_top #(.N(N), .W(W)) i_rank_sort_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_key(in_key),
        .out_valid(out_valid), .out_key(out_key), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected keys as sorted outputs appear (R6, R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected output", int'(out_key), -1);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    check(out_key == e, "R6 sorted key", int'(out_key), int'(e));
                end
            end
            if (done) begin
                check(prev_valid && exp_q.size() == 0, "R8 done after last key",
                      exp_q.size(), 0);
            end
            prev_valid = out_valid;
        end
    end

    // Driver: loads a batch, pushes the stable ascending sort into the scoreboard
    task automatic run_batch(input logic [N-1:0][W-1:0] keys, input string tag);
        logic [W-1:0] s[N];
        for (int i = 0; i < N; i++) s[i] = keys[i];
        for (int i = 1; i < N; i++) begin
            for (int j = i; j > 0 && s[j-1] > s[j]; j--) begin
                logic [W-1:0] t;
                t = s[j]; s[j] = s[j-1]; s[j-1] = t;
            end
        end
        for (int i = 0; i < N; i++) exp_q.push_back(s[i]);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_key   = keys[i];
        end
        @(posedge clk);
        #1;
        // R3: junk keys held valid throughout processing
        in_key = W'($urandom);
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0, {"R7 no output before latency ", tag}, int'(out_valid), 0);
        @(posedge clk);
        #1;
        check(out_valid == 1'b1, {"R7 first output on fourth edge ", tag}, int'(out_valid), 1);
        do @(negedge clk); while (!done);
        in_valid = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, {"R2 all keys emitted ", tag}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [N-1:0][W-1:0] k;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && done == 1'b0, "R1 idle after reset", int'(out_valid), 0);

        // R9: worked example
        k[0] = 9; k[1] = 2; k[2] = 6; k[3] = 4; k[4] = 7; k[5] = 8;
        run_batch(k, "R9");
        // R4/R5: all equal keys, ranks separated only by index
        for (int i = 0; i < N; i++) k[i] = 8'd5;
        run_batch(k, "R4 equal");
        for (int i = 0; i < N; i++) k[i] = W'(N - i);
        run_batch(k, "R6 descending");
        for (int i = 0; i < N; i++) k[i] = W'(i * 3);
        run_batch(k, "R6 ascending");
        k[0] = 0; k[1] = 255; k[2] = 0; k[3] = 255; k[4] = 128; k[5] = 0;
        run_batch(k, "R4 extremes");
        for (int r = 0; r < 20; r++) begin
            for (int i = 0; i < N; i++) k[i] = W'($urandom % 4);
            run_batch(k, "R5 random dup");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule